// File: doc/BRIEF.md
# SCL Timing Generator

This block produces the serial clock of an I2C master from the core clock and tells the data engine beside it when to act. A programmable divider sets the SCL period. Within each period, SCL is pulled low for the first half and released for the second half. Two single-cycle strobes come out of the block. The drive strobe fires a programmed number of core clocks after SCL is pulled low, and the engine puts the next SDA bit on the bus at that point. The sample strobe fires a programmed number of core clocks after SCL is seen high, and the engine captures SDA at that point.

The block senses the real SCL level after it releases the line. A slave can therefore stretch the clock by holding SCL low, and the high phase does not advance while it does. A watchdog counts how long a stretch lasts, in SCL periods. When a stretch goes past a programmed limit, the watchdog sets a sticky timeout flag. A limit of zero turns the watchdog off. START and STOP sequencing and byte shifting belong to the engine that uses these strobes.

The sequencer has four states:
- `ST_IDLE`: disabled, SCL released.
- `ST_LOW`: SCL pulled low while the phase counter runs through half a period.
- `ST_HIGH`: SCL released while the counter runs on each core clock in which SCL is sensed high.
- `ST_STRETCH`: SCL released but sensed low, so the counter is frozen.

The transitions are:
- `ST_IDLE`→`ST_LOW` when enabled.
- `ST_LOW`→`ST_HIGH` at the last low count.
- `ST_HIGH`→`ST_LOW` at the last high count.
- `ST_HIGH`→`ST_STRETCH` when SCL is sensed low.
- `ST_STRETCH`→`ST_HIGH` when SCL is sensed high again.
- Any state →`ST_IDLE` when the enable drops.

Top module: `scl_timing_gen`

## Requirements
- R1: While `en` is low, SCL is released (`scl_pull`=0), neither strobe pulses and `tmo_flag` is 0, starting from the first clock edge that samples `en` low.
- R2: Bit 0 of `div_cfg` is ignored. The SCL period is the even value D = `div_cfg` & ~1 core clocks. Once the enable is sampled, SCL is pulled low for the first D/2 clocks and released for the next D/2 clocks, and this repeats.
- R3: A `div_cfg` value of 0 or 1 behaves exactly as a value of 2.
- R4: `drv_stb` is a one-clock pulse, once per period. It comes F core clocks after the first clock in which SCL is pulled low, where F is `dly_cfg[31:16]`.
- R5: `smp_stb` is a one-clock pulse, once per period. It comes R high-sensed core clocks after SCL is first released and sensed high, where R is `dly_cfg[15:0]`.
- R6: A delay larger than D/2-1 takes effect as D/2-1.
- R7: While SCL is released but sensed low, the high-phase count holds. SCL stays released and no sample strobe is issued. The high phase resumes after the line is sensed high again.
- R8: With `tmo_cfg` = N (N > 0), `tmo_flag` rises once a single stretch has lasted N×D core clocks.
- R9: With `tmo_cfg` = 0, `tmo_flag` never rises, however long the stretch lasts.
- R10: `tmo_flag` stays set until `tmo_clr` is high at a clock edge or the block is disabled. A clear takes priority over a new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| div_cfg | input | 16 | Clock divider; bit 0 is ignored |
| dly_cfg | input | 32 | Falling-edge delay in [31:16], rising-edge delay in [15:0] |
| tmo_cfg | input | 16 | Stretch limit in SCL periods; 0 disables |
| tmo_clr | input | 1 | Clears the timeout flag |
| scl_in | input | 1 | Sensed SCL level |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| drv_stb | output | 1 | Drive-data strobe |
| smp_stb | output | 1 | Sample-data strobe |
| tmo_flag | output | 1 | Sticky stretch timeout flag |

## Verification
The bench builds the block with its default 16-bit divider, delay and timeout widths. With these widths it can run divider values from the degenerate 0 and 1 through 2, odd 9 and even 12. It also uses delays up to twenty, well beyond half a period, so that clamping occurs. In the loopback runs SCL follows the block's own drive, and a scoreboard predicts the clock of every strobe. A forced-low hold exercises stretch, timeout, sticky flag, flag clear and the disabled watchdog, using limits small enough that each window lasts only tens of clocks.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LOW     = 2'd1,
        ST_HIGH    = 2'd2,
        ST_STRETCH = 2'd3
    } scl_state_e;

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode #(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16,
    localparam int HW   = DIV_W - 1
) (
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] dly_cfg,
    output logic [HW-1:0]      half,
    output logic [DIV_W-1:0]   period,
    output logic [HW-1:0]      fall_dly,
    output logic [HW-1:0]      rise_dly
);

    localparam int EW = (DLY_W > HW) ? DLY_W : HW;

    logic [HW-1:0]    half_raw;
    logic [HW-1:0]    lim;
    logic [DLY_W-1:0] fall_raw;
    logic [DLY_W-1:0] rise_raw;

    function automatic logic [HW-1:0] clamp_dly(input logic [DLY_W-1:0] d,
                                                input logic [HW-1:0] l);
        if (EW'(d) > EW'(l))
            return l;
        else
            return HW'(d);
    endfunction

    always_comb begin
        half_raw = div_cfg[DIV_W-1:1];
        half     = (half_raw == '0) ? HW'(1) : half_raw;
        period   = {half, 1'b0};
        lim      = half - HW'(1);
        fall_raw = dly_cfg[2*DLY_W-1:DLY_W];
        rise_raw = dly_cfg[DLY_W-1:0];
        fall_dly = clamp_dly(fall_raw, lim);
        rise_dly = clamp_dly(rise_raw, lim);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int HW   = DIV_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] half,
    input  logic          scl_in,
    output scl_state_e    state,
    output logic [HW-1:0] ph_cnt,
    output logic          scl_pull,
    output logic          stretching
);

    scl_state_e    st_q, st_nx;
    logic [HW-1:0] cnt_q, cnt_nx;
    logic [HW-1:0] last;

    assign last = half - HW'(1);

    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        if (!en) begin
            st_nx  = ST_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_nx  = ST_LOW;
                    cnt_nx = '0;
                end
                ST_LOW: begin
                    if (cnt_q == last) begin
                        st_nx  = ST_HIGH;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt_q + HW'(1);
                    end
                end
                ST_HIGH: begin
                    if (!scl_in) begin
                        st_nx = ST_STRETCH;
                    end else if (cnt_q == last) begin
                        st_nx  = ST_LOW;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt_q + HW'(1);
                    end
                end
                ST_STRETCH: begin
                    if (scl_in)
                        st_nx = ST_HIGH;
                end
                default: begin
                    st_nx  = ST_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        state      = st_q;
        ph_cnt     = cnt_q;
        scl_pull   = (st_q == ST_LOW);
        stretching = (st_q == ST_STRETCH);
    end

endmodule

// File: rtl/edge_strobe_gen.sv
module edge_strobe_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 16,
    localparam int HW   = DIV_W - 1
) (
    input  scl_state_e    state,
    input  logic [HW-1:0] ph_cnt,
    input  logic          scl_in,
    input  logic [HW-1:0] fall_dly,
    input  logic [HW-1:0] rise_dly,
    output logic          drv_stb,
    output logic          smp_stb
);

    always_comb begin
        drv_stb = (state == ST_LOW)  && (ph_cnt == fall_dly);
        smp_stb = (state == ST_HIGH) && scl_in && (ph_cnt == rise_dly);
    end

endmodule

// File: rtl/stretch_watch.sv
module stretch_watch #(
    parameter int DIV_W = 16,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stretching,
    input  logic [DIV_W-1:0] period,
    input  logic [TMO_W-1:0] tmo_cfg,
    input  logic             tmo_clr,
    output logic             tmo_flag
);

    logic [DIV_W-1:0] sub_q;
    logic [TMO_W-1:0] per_q;
    logic             flag_q;
    logic             hit;

    assign hit = stretching && (tmo_cfg != '0) && (per_q >= tmo_cfg);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
            per_q <= '0;
        end else if (!stretching) begin
            sub_q <= '0;
            per_q <= '0;
        end else if (sub_q == period - DIV_W'(1)) begin
            sub_q <= '0;
            if (per_q != '1)
                per_q <= per_q + TMO_W'(1);
        end else begin
            sub_q <= sub_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (!en || tmo_clr)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
    end

    assign tmo_flag = flag_q;

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DLY_W = 16,
    parameter int TMO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [DIV_W-1:0]   div_cfg,
    input  logic [2*DLY_W-1:0] dly_cfg,
    input  logic [TMO_W-1:0]   tmo_cfg,
    input  logic               tmo_clr,
    input  logic               scl_in,
    output logic               scl_pull,
    output logic               drv_stb,
    output logic               smp_stb,
    output logic               tmo_flag
);

    localparam int HW = DIV_W - 1;

    logic [HW-1:0]    half;
    logic [DIV_W-1:0] period;
    logic [HW-1:0]    fall_dly;
    logic [HW-1:0]    rise_dly;
    scl_state_e       state;
    logic [HW-1:0]    ph_cnt;
    logic             stretching;

    scl_cfg_decode #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
        .div_cfg  (div_cfg),
        .dly_cfg  (dly_cfg),
        .half     (half),
        .period   (period),
        .fall_dly (fall_dly),
        .rise_dly (rise_dly)
    );

    scl_phase_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .half       (half),
        .scl_in     (scl_in),
        .state      (state),
        .ph_cnt     (ph_cnt),
        .scl_pull   (scl_pull),
        .stretching (stretching)
    );

    edge_strobe_gen #(.DIV_W(DIV_W)) u_stb (
        .state    (state),
        .ph_cnt   (ph_cnt),
        .scl_in   (scl_in),
        .fall_dly (fall_dly),
        .rise_dly (rise_dly),
        .drv_stb  (drv_stb),
        .smp_stb  (smp_stb)
    );

    stretch_watch #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .stretching (stretching),
        .period     (period),
        .tmo_cfg    (tmo_cfg),
        .tmo_clr    (tmo_clr),
        .tmo_flag   (tmo_flag)
    );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
    parameter int TMO_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [TMO_W-1:0] tmo_cfg,
    input logic             tmo_clr,
    input logic             scl_in,
    input logic             scl_pull,
    input logic             drv_stb,
    input logic             smp_stb,
    input logic             tmo_flag
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_pull && !drv_stb && !smp_stb && !tmo_flag)); // R1

    AST_DRV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        drv_stb |=> !drv_stb); // R4

    AST_DRV_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        drv_stb |-> scl_pull); // R4

    AST_SMP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |=> !smp_stb); // R5

    AST_SMP_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb |-> (!scl_pull && scl_in)); // R5

    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !scl_pull && !scl_in) |-> !smp_stb); // R7

    AST_TMO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmo_flag && tmo_cfg == '0) |=> !tmo_flag); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && en && !tmo_clr) |=> tmo_flag); // R10

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_clr || !en) |=> !tmo_flag); // R10

endmodule

bind scl_timing_gen scl_timing_chk #(.TMO_W(TMO_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tmo_cfg  (tmo_cfg),
    .tmo_clr  (tmo_clr),
    .scl_in   (scl_in),
    .scl_pull (scl_pull),
    .drv_stb  (drv_stb),
    .smp_stb  (smp_stb),
    .tmo_flag (tmo_flag)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] div_cfg = 16'd8;
    logic [31:0] dly_cfg = 32'd0;
    logic [15:0] tmo_cfg = 16'd0;
    logic        tmo_clr = 1'b0;
    logic        hold_low = 1'b0;
    logic        scl_in;
    logic        scl_pull, drv_stb, smp_stb, tmo_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int start_cyc = 0;
    int cur_h = 1;
    int smp_seen = 0;
    bit mon_on = 1'b0;
    bit exp_active = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit kind;   // 0 = drive strobe, 1 = sample strobe
        int t;
    } ev_t;
    ev_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_in = !scl_pull && !hold_low;

    scl_timing_gen u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .div_cfg  (div_cfg),
        .dly_cfg  (dly_cfg),
        .tmo_cfg  (tmo_cfg),
        .tmo_clr  (tmo_clr),
        .scl_in   (scl_in),
        .scl_pull (scl_pull),
        .drv_stb  (drv_stb),
        .smp_stb  (smp_stb),
        .tmo_flag (tmo_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compares strobes against the scoreboard and SCL against the period model
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (smp_stb) smp_seen++;
            if (mon_on) begin
                int t;
                bit exp_low;
                t = cyc - start_cyc - 1;
                exp_low = exp_active && ((t % (2*cur_h)) < cur_h);
                check(scl_pull == exp_low, exp_active ? "R2" : "R1",
                      "SCL level", int'(scl_pull), int'(exp_low));
                if (!exp_active) begin
                    check(!drv_stb && !smp_stb, "R1", "strobe while disabled",
                          int'(drv_stb) + int'(smp_stb), 0);
                end else begin
                    if (drv_stb) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R4", "unexpected drive strobe at t", t, -1);
                        end else begin
                            check(exp_q[0].kind == 1'b0 && exp_q[0].t == t, "R4/R6",
                                  "drive strobe time", t, exp_q[0].t);
                            void'(exp_q.pop_front());
                        end
                    end
                    if (smp_stb) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R5", "unexpected sample strobe at t", t, -1);
                        end else begin
                            check(exp_q[0].kind == 1'b1 && exp_q[0].t == t, "R5/R6",
                                  "sample strobe time", t, exp_q[0].t);
                            void'(exp_q.pop_front());
                        end
                    end
                end
            end
        end
    end

    // Driver: programs a loopback run and pushes the strobes it must produce
    task automatic run_loop(input int div, input int f, input int r, input int periods);
        int h, fe, re, p;
        h  = div / 2;
        if (h == 0) h = 1;
        fe = (f > h - 1) ? h - 1 : f;
        re = (r > h - 1) ? h - 1 : r;
        p  = 2 * h;
        @(negedge clk);
        div_cfg = 16'(div);
        dly_cfg = {16'(f), 16'(r)};
        exp_q.delete();
        for (int k = 0; k < periods; k++) begin
            ev_t e;
            e.kind = 1'b0; e.t = k * p + fe; exp_q.push_back(e);
            e.kind = 1'b1; e.t = k * p + h + re; exp_q.push_back(e);
        end
        cur_h = h;
        start_cyc = cyc;
        exp_active = 1'b1;
        en = 1'b1;
        repeat (periods * p) @(negedge clk);
        en = 1'b0;
        exp_active = 1'b0;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4/R5", "strobes never produced", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and disabled state
        check(scl_pull == 1'b0, "R1", "SCL released after reset", int'(scl_pull), 0);
        check(drv_stb == 1'b0 && smp_stb == 1'b0, "R1", "strobes after reset",
              int'(drv_stb) + int'(smp_stb), 0);
        check(tmo_flag == 1'b0, "R1", "flag after reset", int'(tmo_flag), 0);
        mon_on = 1'b1;

        run_loop(8, 1, 2, 3);    // R2 R4 R5 basic
        run_loop(9, 0, 3, 2);    // R2 odd divider acts as 8
        run_loop(12, 5, 0, 2);   // R4 R5 other offsets
        run_loop(2, 0, 0, 3);    // R2 minimum divider
        run_loop(1, 0, 0, 2);    // R3 divider 1 acts as 2
        run_loop(0, 0, 0, 2);    // R3 divider 0 acts as 2
        run_loop(8, 7, 20, 2);   // R6 both delays clamp to 3
        mon_on = 1'b0;

        // R7 / R8: stretch with limit 3 periods of 8 clocks
        begin
            int base;
            @(negedge clk);
            div_cfg = 16'd8; dly_cfg = {16'd1, 16'd1}; tmo_cfg = 16'd3;
            hold_low = 1'b1;
            en = 1'b1;
            base = smp_seen;
            repeat (25) @(negedge clk);   // now in cycle t=24
            check(tmo_flag == 1'b0, "R8", "flag before limit", int'(tmo_flag), 0);
            check(scl_pull == 1'b0, "R7", "SCL held released while stretched", int'(scl_pull), 0);
            repeat (10) @(negedge clk);   // cycle t=34
            check(tmo_flag == 1'b1, "R8", "flag after limit", int'(tmo_flag), 1);
            check(smp_seen == base, "R7", "sample strobes during stretch", smp_seen - base, 0);
            hold_low = 1'b0;
            repeat (3) @(negedge clk);
            check(smp_seen == base + 1, "R7", "sample strobe after stretch ends",
                  smp_seen - base, 1);
            repeat (4) @(negedge clk);
            check(scl_pull == 1'b1, "R7", "high phase resumes then SCL pulled low",
                  int'(scl_pull), 1);
            check(tmo_flag == 1'b1, "R10", "flag sticky after stretch", int'(tmo_flag), 1);
            tmo_clr = 1'b1;
            @(negedge clk);
            tmo_clr = 1'b0;
            check(tmo_flag == 1'b0, "R10", "flag cleared by tmo_clr", int'(tmo_flag), 0);
            en = 1'b0;
        end

        // R9: limit 0 never flags
        @(negedge clk);
        tmo_cfg = 16'd0;
        hold_low = 1'b1;
        en = 1'b1;
        repeat (200) @(negedge clk);
        check(tmo_flag == 1'b0, "R9", "flag with limit 0", int'(tmo_flag), 0);
        en = 1'b0;
        hold_low = 1'b0;

        // R10 / R1: disabling clears the flag
        @(negedge clk);
        tmo_cfg = 16'd1;
        hold_low = 1'b1;
        en = 1'b1;
        repeat (30) @(negedge clk);
        check(tmo_flag == 1'b1, "R8", "flag with limit 1", int'(tmo_flag), 1);
        en = 1'b0;
        @(negedge clk);
        check(tmo_flag == 1'b0, "R10", "flag cleared by disable", int'(tmo_flag), 0);
        check(scl_pull == 1'b0, "R1", "SCL released when disabled", int'(scl_pull), 0);
        hold_low = 1'b0;

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule